// File: doc/BRIEF.md
# SR-IOV Virtual Function Routing-ID Decoder

This block takes a device/function number seen on the physical function's bus and reports whether it belongs to one of the live virtual functions, and if it does, which one. Virtual function `i` sits at `pf_devfn + vf_offset + vf_stride * i`. Only indices below the effective enabled count take part. The same arithmetic drives a second port. That port turns a virtual-function index back into its routing ID.

The block also checks the layout that the offset, stride and total count describe. The checks cover a last function past the 8-bit space, a zero stride with more than one function, more functions than the decoder instance holds, and a device-number mismatch when alternative routing-ID interpretation is absent. A bad layout raises `cfg_err` and suppresses every match.

The block is a single register stage. Every output reflects the inputs present at the previous rising clock edge. A three-state mode register follows the configuration. `MODE_OFF` means nothing is enabled, `MODE_LIVE` means matches are possible and `MODE_FAULT` means the layout is invalid. The next mode is picked every cycle with this priority: an invalid layout goes to `MODE_FAULT` (transition *fault*); otherwise a non-zero effective count goes to `MODE_LIVE` (transition *arm*); otherwise the block goes to `MODE_OFF` (transition *idle*). Any state can reach any other state in one cycle. Reset puts the block in `MODE_OFF`.

Top module: `vf_rid_decoder`

## Requirements
- R1: The routing ID of virtual function `i` is `pf_devfn + vf_offset + vf_stride*i`. When `lk_idx` names an index below the effective count, `lk_rid` shows the low 8 bits of that ID one cycle later.
- R2: When `req_valid` is 1 and `req_devfn` equals the routing ID of some index below the effective count, `hit` is 1 and `vf_idx` holds that index one cycle later. If several indices match, the lowest one wins.
- R3: If `pf_devfn + vf_offset + vf_stride*(total_vfs-1)` is 256 or more, `cfg_err` is 1. A full-width sum whose low byte equals `req_devfn` still gives no hit.
- R4: When `ari_present` is 0, the last function's bits [7:3] must equal bits [7:3] of `pf_devfn`, otherwise `cfg_err` is 1. When `ari_present` is 1, this check is skipped.
- R5: A zero stride with `total_vfs` above 1 sets `cfg_err`, and so does `total_vfs` above `MAX_VFS`. A zero stride with exactly one function is valid.
- R6: While the layout is invalid, `hit` and `lk_ok` are 0, even for a `req_devfn` that lands on a computed ID.
- R7: The effective count is `num_vfs` when `vf_enable` is 1 and `num_vfs <= total_vfs`, and 0 otherwise. With an effective count of 0 there is no hit.
- R8: Indices at or above the effective count never hit, and a lookup of such an index gives `lk_ok` = 0.
- R9: With `total_vfs` = 0, `cfg_err` is 0 and `hit` is 0 whatever the other fields hold.
- R10: After reset all outputs are 0. With `req_valid` = 0, `hit` is 0.
- R11: The latency is exactly one clock. A change of the inputs does not show on the outputs before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_devfn | input | 8 | Device/function number of the physical function |
| vf_offset | input | 16 | Distance from the PF to the first VF |
| vf_stride | input | 16 | Distance between consecutive VFs |
| total_vfs | input | 16 | Number of VFs in the layout |
| num_vfs | input | 16 | Number of VFs software asked to enable |
| vf_enable | input | 1 | Global VF enable |
| ari_present | input | 1 | Alternative routing-ID interpretation present |
| req_valid | input | 1 | `req_devfn` carries a request |
| req_devfn | input | 8 | Device/function number to decode |
| lk_idx | input | 4 | VF index for the reverse lookup |
| hit | output | 1 | `req_devfn` matched a live VF |
| vf_idx | output | 4 | Index of the matched VF |
| cfg_err | output | 1 | Layout is invalid |
| lk_ok | output | 1 | `lk_idx` names a live VF |
| lk_rid | output | 8 | Routing ID computed for `lk_idx` |

## Verification
The hardest case to reach from the ports is a full-width routing ID whose low byte coincides with the request while its upper bits put it past the 8-bit space. A decoder that truncates early would report a false hit. The stimulus reaches this case with an offset of 256 and a request of 0. The stimulus also places a request exactly on the routing ID of an index just above the enabled count, so that only the count comparison prevents the match. In the same way, it places a request on a valid-looking ID inside a layout that only the device-number rule rejects.

// File: rtl/vfrid_pkg.sv
package vfrid_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_LIVE  = 2'd1,
        MODE_FAULT = 2'd2
    } mode_e;

    localparam int FUNC_BITS = 3;

endpackage

// File: rtl/vfrid_layout_check.sv
module vfrid_layout_check #(
    parameter int DEVFN_W = 8,
    parameter int CNT_W   = 16,
    parameter int MAX_VFS = 16
) (
    input  logic [DEVFN_W-1:0] pf_devfn,
    input  logic [CNT_W-1:0]   vf_offset,
    input  logic [CNT_W-1:0]   vf_stride,
    input  logic [CNT_W-1:0]   total_vfs,
    input  logic               ari_present,
    output logic               cfg_bad
);
    import vfrid_pkg::*;

    localparam int WIDE_W = 2*CNT_W + 2;
    localparam logic [WIDE_W-1:0] SPACE = WIDE_W'(1) << DEVFN_W;

    logic [WIDE_W-1:0] last_rid;
    logic [CNT_W-1:0]  last_idx;
    logic              past_space;
    logic              slot_differs;
    logic              stride_void;
    logic              too_many;

    always_comb begin
        last_idx     = total_vfs - CNT_W'(1);
        last_rid     = WIDE_W'(pf_devfn) + WIDE_W'(vf_offset)
                     + WIDE_W'(vf_stride) * WIDE_W'(last_idx);
        past_space   = (last_rid >= SPACE);
        slot_differs = !ari_present &&
                       (last_rid[DEVFN_W-1:FUNC_BITS] != pf_devfn[DEVFN_W-1:FUNC_BITS]);
        stride_void  = (vf_stride == '0) && (total_vfs > CNT_W'(1));
        too_many     = (total_vfs > CNT_W'(MAX_VFS));
        cfg_bad      = (total_vfs != '0) &&
                       (past_space || slot_differs || stride_void || too_many);
    end

endmodule

// File: rtl/vfrid_match.sv
module vfrid_match #(
    parameter int DEVFN_W = 8,
    parameter int CNT_W   = 16,
    parameter int MAX_VFS = 16,
    parameter int IDX_W   = $clog2(MAX_VFS)
) (
    input  logic [DEVFN_W-1:0] pf_devfn,
    input  logic [CNT_W-1:0]   vf_offset,
    input  logic [CNT_W-1:0]   vf_stride,
    input  logic [CNT_W-1:0]   eff_cnt,
    input  logic [DEVFN_W-1:0] req_devfn,
    output logic               any_match,
    output logic [IDX_W-1:0]   match_idx
);
    localparam int WIDE_W = 2*CNT_W + 2;

    logic [MAX_VFS-1:0] cand;

    for (genvar i = 0; i < MAX_VFS; i++) begin : g_slot
        localparam logic [WIDE_W-1:0] IW = WIDE_W'(i);
        logic [WIDE_W-1:0] rid_w;
        always_comb begin
            rid_w   = WIDE_W'(pf_devfn) + WIDE_W'(vf_offset) + WIDE_W'(vf_stride) * IW;
            cand[i] = (CNT_W'(i) < eff_cnt) && (rid_w == WIDE_W'(req_devfn));
        end
    end

    always_comb begin
        any_match = 1'b0;
        match_idx = '0;
        for (int k = MAX_VFS - 1; k >= 0; k--) begin
            if (cand[k]) begin
                any_match = 1'b1;
                match_idx = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/vfrid_index_lookup.sv
module vfrid_index_lookup #(
    parameter int DEVFN_W = 8,
    parameter int CNT_W   = 16,
    parameter int IDX_W   = 4
) (
    input  logic [DEVFN_W-1:0] pf_devfn,
    input  logic [CNT_W-1:0]   vf_offset,
    input  logic [CNT_W-1:0]   vf_stride,
    input  logic [CNT_W-1:0]   eff_cnt,
    input  logic [IDX_W-1:0]   lk_idx,
    output logic [DEVFN_W-1:0] rid,
    output logic               in_range
);
    localparam int WIDE_W = 2*CNT_W + 2;

    logic [WIDE_W-1:0] rid_w;

    always_comb begin
        rid_w    = WIDE_W'(pf_devfn) + WIDE_W'(vf_offset)
                 + WIDE_W'(vf_stride) * WIDE_W'(lk_idx);
        rid      = rid_w[DEVFN_W-1:0];
        in_range = (CNT_W'(lk_idx) < eff_cnt);
    end

endmodule

// File: rtl/vf_rid_decoder.sv
module vf_rid_decoder #(
    parameter int DEVFN_W = 8,
    parameter int CNT_W   = 16,
    parameter int MAX_VFS = 16,
    parameter int IDX_W   = $clog2(MAX_VFS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DEVFN_W-1:0] pf_devfn,
    input  logic [CNT_W-1:0]   vf_offset,
    input  logic [CNT_W-1:0]   vf_stride,
    input  logic [CNT_W-1:0]   total_vfs,
    input  logic [CNT_W-1:0]   num_vfs,
    input  logic               vf_enable,
    input  logic               ari_present,
    input  logic               req_valid,
    input  logic [DEVFN_W-1:0] req_devfn,
    input  logic [IDX_W-1:0]   lk_idx,
    output logic               hit,
    output logic [IDX_W-1:0]   vf_idx,
    output logic               cfg_err,
    output logic               lk_ok,
    output logic [DEVFN_W-1:0] lk_rid
);
    import vfrid_pkg::*;

    mode_e              mode_q;
    mode_e              mode_nxt;
    logic [CNT_W-1:0]   eff_cnt;
    logic               err_c;
    logic               any_c;
    logic [IDX_W-1:0]   idx_c;
    logic [DEVFN_W-1:0] rid_c;
    logic               range_c;

    always_comb begin
        eff_cnt = (vf_enable && (num_vfs <= total_vfs)) ? num_vfs : '0;
    end

    vfrid_layout_check #(
        .DEVFN_W(DEVFN_W), .CNT_W(CNT_W), .MAX_VFS(MAX_VFS)
    ) u_check (
        .pf_devfn    (pf_devfn),
        .vf_offset   (vf_offset),
        .vf_stride   (vf_stride),
        .total_vfs   (total_vfs),
        .ari_present (ari_present),
        .cfg_bad     (err_c)
    );

    vfrid_match #(
        .DEVFN_W(DEVFN_W), .CNT_W(CNT_W), .MAX_VFS(MAX_VFS), .IDX_W(IDX_W)
    ) u_match (
        .pf_devfn  (pf_devfn),
        .vf_offset (vf_offset),
        .vf_stride (vf_stride),
        .eff_cnt   (eff_cnt),
        .req_devfn (req_devfn),
        .any_match (any_c),
        .match_idx (idx_c)
    );

    vfrid_index_lookup #(
        .DEVFN_W(DEVFN_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_lookup (
        .pf_devfn  (pf_devfn),
        .vf_offset (vf_offset),
        .vf_stride (vf_stride),
        .eff_cnt   (eff_cnt),
        .lk_idx    (lk_idx),
        .rid       (rid_c),
        .in_range  (range_c)
    );

    // next mode: fault has priority, then arm, else idle
    always_comb begin
        if (err_c)
            mode_nxt = MODE_FAULT;
        else if (eff_cnt != '0)
            mode_nxt = MODE_LIVE;
        else
            mode_nxt = MODE_OFF;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_OFF;
        else
            mode_q <= mode_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit     <= 1'b0;
            vf_idx  <= '0;
            cfg_err <= 1'b0;
            lk_ok   <= 1'b0;
            lk_rid  <= '0;
        end else begin
            lk_rid <= rid_c;
            unique case (mode_nxt)
                MODE_FAULT: begin
                    hit     <= 1'b0;
                    vf_idx  <= '0;
                    cfg_err <= 1'b1;
                    lk_ok   <= 1'b0;
                end
                MODE_LIVE: begin
                    hit     <= req_valid && any_c;
                    vf_idx  <= any_c ? idx_c : '0;
                    cfg_err <= 1'b0;
                    lk_ok   <= range_c;
                end
                MODE_OFF: begin
                    hit     <= 1'b0;
                    vf_idx  <= '0;
                    cfg_err <= 1'b0;
                    lk_ok   <= 1'b0;
                end
                default: begin
                    hit     <= 1'b0;
                    vf_idx  <= '0;
                    cfg_err <= 1'b0;
                    lk_ok   <= 1'b0;
                end
            endcase
        end
    end

    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r6_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!hit && !lk_ok));

    a_r6_fault_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_FAULT) |-> cfg_err);

    a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(vf_enable)) |-> (!hit && !lk_ok));

    a_r8_hit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && hit) |-> (CNT_W'(vf_idx) < $past(num_vfs)));

    a_r8_lookup_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (CNT_W'($past(lk_idx)) >= $past(num_vfs))) |-> !lk_ok);

    a_r9_empty_layout: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && ($past(total_vfs) == '0)) |-> (!hit && !cfg_err));

    a_r10_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(req_valid)) |-> !hit);

endmodule

// File: tb/vf_rid_decoder_test.sv
module vf_rid_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pf_devfn = '0;
    logic [15:0] vf_offset = '0;
    logic [15:0] vf_stride = '0;
    logic [15:0] total_vfs = '0;
    logic [15:0] num_vfs = '0;
    logic        vf_enable = 1'b0;
    logic        ari_present = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_devfn = '0;
    logic [3:0]  lk_idx = '0;
    logic        hit;
    logic [3:0]  vf_idx;
    logic        cfg_err;
    logic        lk_ok;
    logic [7:0]  lk_rid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vf_rid_decoder uut (
        .clk(clk), .rst_n(rst_n), .pf_devfn(pf_devfn), .vf_offset(vf_offset),
        .vf_stride(vf_stride), .total_vfs(total_vfs), .num_vfs(num_vfs),
        .vf_enable(vf_enable), .ari_present(ari_present), .req_valid(req_valid),
        .req_devfn(req_devfn), .lk_idx(lk_idx), .hit(hit), .vf_idx(vf_idx),
        .cfg_err(cfg_err), .lk_ok(lk_ok), .lk_rid(lk_rid)
    );

    typedef struct packed {
        logic [7:0]  rq;
        logic [7:0]  pf;
        logic [15:0] off;
        logic [15:0] stride;
        logic [15:0] total;
        logic [15:0] num;
        logic        en;
        logic        ari;
        logic [7:0]  dv;
        logic        ehit;
        logic [3:0]  eidx;
        logic        eerr;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{8'd2, 8'h10, 16'h1,   16'h1,  16'd4,  16'd4, 1'b1, 1'b0, 8'h13, 1'b1, 4'd2, 1'b0}, // R2
        '{8'd2, 8'h10, 16'h1,   16'h1,  16'd4,  16'd4, 1'b1, 1'b0, 8'h10, 1'b0, 4'd0, 1'b0}, // R2 PF itself
        '{8'd8, 8'h10, 16'h1,   16'h1,  16'd4,  16'd2, 1'b1, 1'b0, 8'h13, 1'b0, 4'd0, 1'b0}, // R8 above count
        '{8'd8, 8'h10, 16'h1,   16'h1,  16'd4,  16'd2, 1'b1, 1'b0, 8'h12, 1'b1, 4'd1, 1'b0}, // R8 last live
        '{8'd7, 8'h10, 16'h1,   16'h1,  16'd4,  16'd4, 1'b0, 1'b0, 8'h11, 1'b0, 4'd0, 1'b0}, // R7 disabled
        '{8'd1, 8'h10, 16'h1,   16'h2,  16'd4,  16'd4, 1'b1, 1'b0, 8'h15, 1'b1, 4'd2, 1'b0}, // R1 stride 2
        '{8'd4, 8'h10, 16'h4,   16'h2,  16'd4,  16'd4, 1'b1, 1'b0, 8'h14, 1'b0, 4'd0, 1'b1}, // R4 slot mismatch
        '{8'd4, 8'h10, 16'h4,   16'h2,  16'd4,  16'd4, 1'b1, 1'b1, 8'h1A, 1'b1, 4'd3, 1'b0}, // R4 ARI skips
        '{8'd3, 8'hF0, 16'h8,   16'h4,  16'd4,  16'd4, 1'b1, 1'b1, 8'hF8, 1'b0, 4'd0, 1'b1}, // R3 past 255
        '{8'd2, 8'h00, 16'h80,  16'h20, 16'd4,  16'd4, 1'b1, 1'b1, 8'hC0, 1'b1, 4'd2, 1'b0}, // R2 wide stride
        '{8'd5, 8'h00, 16'h1,   16'h0,  16'd2,  16'd2, 1'b1, 1'b1, 8'h01, 1'b0, 4'd0, 1'b1}, // R5 zero stride
        '{8'd5, 8'h08, 16'h1,   16'h0,  16'd1,  16'd1, 1'b1, 1'b0, 8'h09, 1'b1, 4'd0, 1'b0}, // R5 single VF
        '{8'd9, 8'h10, 16'h80,  16'h1,  16'd0,  16'd0, 1'b1, 1'b0, 8'h90, 1'b0, 4'd0, 1'b0}, // R9 empty
        '{8'd5, 8'h00, 16'h1,   16'h1,  16'd20, 16'd4, 1'b1, 1'b1, 8'h02, 1'b0, 4'd0, 1'b1}, // R5 too many
        '{8'd7, 8'h10, 16'h1,   16'h1,  16'd4,  16'd5, 1'b1, 1'b0, 8'h11, 1'b0, 4'd0, 1'b0}, // R7 num > total
        '{8'd3, 8'h00, 16'h100, 16'h1,  16'd1,  16'd1, 1'b1, 1'b1, 8'h00, 1'b0, 4'd0, 1'b1}, // R3 aliasing byte
        '{8'd6, 8'h10, 16'h4,   16'h2,  16'd4,  16'd4, 1'b1, 1'b0, 8'h1A, 1'b0, 4'd0, 1'b1}  // R6 bad layout
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic setup(input logic [7:0] pf, input logic [15:0] off, input logic [15:0] st,
                         input logic [15:0] tot, input logic [15:0] num, input logic en,
                         input logic ari);
        pf_devfn = pf; vf_offset = off; vf_stride = st;
        total_vfs = tot; num_vfs = num; vf_enable = en; ari_present = ari;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        setup(8'h10, 16'h1, 16'h1, 16'd4, 16'd4, 1'b1, 1'b0);
        req_valid = 1'b1; req_devfn = 8'h11; lk_idx = 4'd1;
        repeat (3) @(negedge clk);
        chk("R10 reset hit", 32'(hit), 32'd0);
        chk("R10 reset cfg_err", 32'(cfg_err), 32'd0);
        chk("R10 reset lk_ok", 32'(lk_ok), 32'd0);
        rst_n = 1'b1;
        lk_idx = 4'd0;

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            setup(TBL[v].pf, TBL[v].off, TBL[v].stride, TBL[v].total, TBL[v].num,
                  TBL[v].en, TBL[v].ari);
            req_valid = 1'b1; req_devfn = TBL[v].dv;
            @(negedge clk);
            chk($sformatf("R%0d row%0d hit", TBL[v].rq, v), 32'(hit), 32'(TBL[v].ehit));
            chk($sformatf("R%0d row%0d cfg_err", TBL[v].rq, v), 32'(cfg_err), 32'(TBL[v].eerr));
            if (TBL[v].ehit)
                chk($sformatf("R%0d row%0d vf_idx", TBL[v].rq, v), 32'(vf_idx), 32'(TBL[v].eidx));
        end

        // R1 lookup: pf 0x10, offset 1, stride 1, 3 of 4 enabled
        @(negedge clk);
        setup(8'h10, 16'h1, 16'h1, 16'd4, 16'd3, 1'b1, 1'b0);
        req_valid = 1'b0; lk_idx = 4'd2;
        @(negedge clk);
        chk("R1 lookup rid", 32'(lk_rid), 32'h13);
        chk("R1 lookup ok", 32'(lk_ok), 32'd1);
        chk("R10 idle request", 32'(hit), 32'd0);
        lk_idx = 4'd3;
        @(negedge clk);
        chk("R8 lookup past count", 32'(lk_ok), 32'd0);

        // R1 stride 2 lookup
        setup(8'h10, 16'h1, 16'h2, 16'd4, 16'd4, 1'b1, 1'b0);
        @(negedge clk);
        chk("R1 stride lookup rid", 32'(lk_rid), 32'h17);
        chk("R1 stride lookup ok", 32'(lk_ok), 32'd1);

        // R6 lookup blocked under a bad layout
        setup(8'h10, 16'h4, 16'h2, 16'd4, 16'd4, 1'b1, 1'b0);
        lk_idx = 4'd0;
        @(negedge clk);
        chk("R6 lookup blocked", 32'(lk_ok), 32'd0);

        // R11 latency: no change before the edge, change after it
        setup(8'h10, 16'h1, 16'h1, 16'd4, 16'd4, 1'b1, 1'b0);
        req_valid = 1'b1; req_devfn = 8'h10;
        @(negedge clk);
        chk("R11 settle no hit", 32'(hit), 32'd0);
        req_devfn = 8'h14;
        #1;
        chk("R11 before edge", 32'(hit), 32'd0);
        @(negedge clk);
        chk("R11 after edge", 32'(hit), 32'd1);
        chk("R11 after edge idx", 32'(vf_idx), 32'd3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule